// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Extension

This block is the integer datapath of a 32-bit, three-operand, load/store processor. It takes two register operands, a 16-bit immediate, a 5-bit constant shift amount and a 5-bit operation code. From these it produces a 32-bit result for additions, subtractions, bitwise logic, set-on-less-than compares, shifts and upper-half immediate loads. The second operand comes either from the register input or from the immediate. How the immediate is widened depends on the operation: operations in the arithmetic family always widen it with its sign, and bitwise operations always widen it with zeros.

Only three operations can raise the overflow trap: signed add, signed subtract and signed add-immediate. A trapping operation drops the result-valid output, so the destination register is never written. The unsigned add and subtract variants wrap silently. The datapath is combinational. A parameter can add one register stage at the output, and that stage is enabled by default.

Top module: `int_exec_unit`

## Requirements
- R1: ADD (0), ADDU (1), SUB (2) and SUBU (3) return src_a plus or minus src_b modulo 2^32.
- R2: AND (4), OR (5), XOR (6) and NOR (7) apply the bitwise function to src_a and src_b.
- R3: ANDI (14), ORI (15) and XORI (16) use the immediate with bits 31:16 cleared as the second operand, whatever the value of imm bit 15.
- R4: ADDI (10), ADDIU (11), SLTI (12) and SLTIU (13) use the immediate with bit 15 copied into bits 31:16, including for the two unsigned variants.
- R5: SLT (8) and SLTI compare as two's complement, and SLTU (9) and SLTIU compare as unsigned. The result is 1 or 0 in bit 0, and bits 31:1 are zero. So 0xFFFFFFFF is less than 1 for SLT and not less than 1 for SLTU.
- R6: LUI (17) returns imm in bits 31:16 and zeros in bits 15:0.
- R7: SLL (18), SRL (19) and SRA (20) shift src_b by shamt. SLLV (21), SRLV (22) and SRAV (23) shift src_b by src_a[4:0] only and ignore src_a[31:5]. The arithmetic right shifts fill with src_b bit 31, and the logical shifts fill with zeros.
- R8: ovf_trap is raised only for a valid ADD, SUB or ADDI whose signed result does not fit in 32 bits. ADDU, SUBU, ADDIU, the logical operations, the compares, the shifts and LUI never raise it.
- R9: When ovf_trap is raised, result_valid is low, and result still carries the wrapped sum or difference.
- R10: result_valid is high only for op_valid=1 with a code from 0 to 23. Codes 24 to 31 give result 0, result_valid 0 and ovf_trap 0.
- R11: With REG_OUT=1, all outputs appear one clock after the inputs. While rst_n is low, result, result_valid and ovf_trap are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | The operation on the inputs is real |
| op_code | input | 5 | Operation selector (codes listed in the requirements) |
| src_a | input | 32 | First register operand; low 5 bits are the variable shift amount |
| src_b | input | 32 | Second register operand; the shifted value for shifts |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| result_valid | output | 1 | Result may be written to the destination |
| ovf_trap | output | 1 | Signed overflow trap |

## Verification
The bench targets the following corner cases:
- Add-immediate with the immediate 0x8000 (-32768) and bitwise AND-immediate with the same immediate. A design that widened both immediates the same way would give a wrong result for one of them.
- The all-ones operand compared with 1 in signed and in unsigned form. A design that mixed the two comparisons would return the same bit for both.
- Signed add and subtract at the positive and negative limits, with the unsigned forms given the same operands. Here a design could miss the trap, could trap on the unsigned form, or could leave result_valid high during a trap.
- Variable shifts with src_a set above 31, and an arithmetic right shift of a negative value. These expose a design that uses the wide shift amount or fills with the wrong bit.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
      OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR   = 5'd7,
      OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_ADDI  = 5'd10, OP_ADDIU = 5'd11,
      OP_SLTI  = 5'd12, OP_SLTIU = 5'd13, OP_ANDI  = 5'd14, OP_ORI   = 5'd15,
      OP_XORI  = 5'd16, OP_LUI   = 5'd17, OP_SLL   = 5'd18, OP_SRL   = 5'd19,
      OP_SRA   = 5'd20, OP_SLLV  = 5'd21, OP_SRLV  = 5'd22, OP_SRAV  = 5'd23
   } ix_op_e;

   localparam logic [4:0] IX_LAST_OP = 5'd23;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOR = 2'd3
   } ix_lgc_e;

   typedef enum logic [2:0] {
      RS_SUM   = 3'd0,
      RS_LOGIC = 3'd1,
      RS_LESS  = 3'd2,
      RS_SHIFT = 3'd3,
      RS_UPPER = 3'd4,
      RS_ZERO  = 3'd5
   } ix_rsel_e;

endpackage

// File: rtl/ix_imm_ext.sv
module ix_imm_ext #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [IMM_W-1:0]  imm_in,
   output logic [DATA_W-1:0] imm_sext,
   output logic [DATA_W-1:0] imm_zext,
   output logic [DATA_W-1:0] imm_upper
);
   localparam int PAD_W = DATA_W - IMM_W;

   assign imm_sext  = {{PAD_W{imm_in[IMM_W-1]}}, imm_in};
   assign imm_zext  = {{PAD_W{1'b0}}, imm_in};

   generate
      if (PAD_W >= IMM_W) begin : g_up_fit
         assign imm_upper = {imm_in, {(DATA_W-IMM_W){1'b0}}};
      end else begin : g_up_trunc
         assign imm_upper = {imm_in[PAD_W-1:0], {IMM_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/ix_addsub.sv
module ix_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              do_sub,
   output logic [DATA_W-1:0] sum,
   output logic              ovf,
   output logic              less_s,
   output logic              less_u
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff = do_sub ? ~op_b : op_b;
   assign wide  = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
   assign sum   = wide[MSB:0];

   // signed overflow: operands (after inversion) share a sign that the sum lost
   assign ovf    = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
   // compare results are meaningful only with do_sub set
   assign less_u = ~wide[DATA_W];
   assign less_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : sum[MSB];
endmodule

// File: rtl/ix_logic.sv
module ix_logic #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]       op_a,
   input  logic [DATA_W-1:0]       op_b,
   input  int_exec_pkg::ix_lgc_e   fn,
   output logic [DATA_W-1:0]       res
);
   import int_exec_pkg::*;

   always_comb begin
      unique case (fn)
         LG_AND:  res = op_a & op_b;
         LG_OR:   res = op_a | op_b;
         LG_XOR:  res = op_a ^ op_b;
         default: res = ~(op_a | op_b);
      endcase
   end
endmodule

// File: rtl/ix_shifter.sv
module ix_shifter #(
   parameter int DATA_W = 32,
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   input  logic              to_left,
   input  logic              arith,
   output logic [DATA_W-1:0] dout
);
   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int k = 0; k < DATA_W; k++) r[k] = v[DATA_W-1-k];
      return r;
   endfunction

   logic                fill;
   logic [DATA_W-1:0]   stg [0:SH_W];

   assign fill   = arith & ~to_left & din[DATA_W-1];
   assign stg[0] = to_left ? flip(din) : din;

   generate
      for (genvar i = 0; i < SH_W; i++) begin : g_stage
         localparam int D = 1 << i;
         assign stg[i+1] = amt[i] ? {{D{fill}}, stg[i][DATA_W-1:D]} : stg[i];
      end
   endgenerate

   assign dout = to_left ? flip(stg[SH_W]) : stg[SH_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      op_valid,
   input  logic [4:0]                op_code,
   input  logic [DATA_W-1:0]         src_a,
   input  logic [DATA_W-1:0]         src_b,
   input  logic [IMM_W-1:0]          imm,
   input  logic [$clog2(DATA_W)-1:0] shamt,
   output logic [DATA_W-1:0]         result,
   output logic                      result_valid,
   output logic                      ovf_trap
);
   import int_exec_pkg::*;

   localparam int SH_W = $clog2(DATA_W);

   generate
      if (DATA_W <= IMM_W || (1 << SH_W) != DATA_W) begin : g_bad_cfg
         $error("int_exec_unit: DATA_W must be a power of two wider than IMM_W");
      end
   endgenerate

   ix_op_e             op_e;
   logic               op_known;
   logic               imm_arith, imm_logic, sub_sel, trap_op;
   logic               sh_left, sh_arith, sh_var;
   ix_lgc_e            lg_fn;
   ix_rsel_e           rsel;
   logic               less_bit, less_unsigned;
   logic [DATA_W-1:0]  sext_w, zext_w, upper_w, opnd_b;
   logic [DATA_W-1:0]  sum_w, logic_w, shift_w;
   logic               ovf_w, lt_s_w, lt_u_w;
   logic [SH_W-1:0]    sh_amt;
   logic [DATA_W-1:0]  c_result;
   logic               c_valid, c_trap;

   assign op_e     = ix_op_e'(op_code);
   assign op_known = (op_code <= IX_LAST_OP);

   // decode
   always_comb begin
      imm_arith     = 1'b0;
      imm_logic     = 1'b0;
      sub_sel       = 1'b0;
      trap_op       = 1'b0;
      sh_left       = 1'b0;
      sh_arith      = 1'b0;
      sh_var        = 1'b0;
      less_unsigned = 1'b0;
      lg_fn         = LG_AND;
      rsel          = RS_ZERO;
      case (op_e)
         OP_ADD:   begin rsel = RS_SUM; trap_op = 1'b1; end
         OP_ADDU:  rsel = RS_SUM;
         OP_SUB:   begin rsel = RS_SUM; sub_sel = 1'b1; trap_op = 1'b1; end
         OP_SUBU:  begin rsel = RS_SUM; sub_sel = 1'b1; end
         OP_AND:   begin rsel = RS_LOGIC; lg_fn = LG_AND; end
         OP_OR:    begin rsel = RS_LOGIC; lg_fn = LG_OR;  end
         OP_XOR:   begin rsel = RS_LOGIC; lg_fn = LG_XOR; end
         OP_NOR:   begin rsel = RS_LOGIC; lg_fn = LG_NOR; end
         OP_SLT:   begin rsel = RS_LESS; sub_sel = 1'b1; end
         OP_SLTU:  begin rsel = RS_LESS; sub_sel = 1'b1; less_unsigned = 1'b1; end
         OP_ADDI:  begin rsel = RS_SUM; imm_arith = 1'b1; trap_op = 1'b1; end
         OP_ADDIU: begin rsel = RS_SUM; imm_arith = 1'b1; end
         OP_SLTI:  begin rsel = RS_LESS; imm_arith = 1'b1; sub_sel = 1'b1; end
         OP_SLTIU: begin rsel = RS_LESS; imm_arith = 1'b1; sub_sel = 1'b1;
                         less_unsigned = 1'b1; end
         OP_ANDI:  begin rsel = RS_LOGIC; imm_logic = 1'b1; lg_fn = LG_AND; end
         OP_ORI:   begin rsel = RS_LOGIC; imm_logic = 1'b1; lg_fn = LG_OR;  end
         OP_XORI:  begin rsel = RS_LOGIC; imm_logic = 1'b1; lg_fn = LG_XOR; end
         OP_LUI:   rsel = RS_UPPER;
         OP_SLL:   begin rsel = RS_SHIFT; sh_left = 1'b1; end
         OP_SRL:   rsel = RS_SHIFT;
         OP_SRA:   begin rsel = RS_SHIFT; sh_arith = 1'b1; end
         OP_SLLV:  begin rsel = RS_SHIFT; sh_left = 1'b1; sh_var = 1'b1; end
         OP_SRLV:  begin rsel = RS_SHIFT; sh_var = 1'b1; end
         OP_SRAV:  begin rsel = RS_SHIFT; sh_arith = 1'b1; sh_var = 1'b1; end
         default:  rsel = RS_ZERO;
      endcase
   end

   ix_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
      .imm_in   (imm),
      .imm_sext (sext_w),
      .imm_zext (zext_w),
      .imm_upper(upper_w)
   );

   assign opnd_b = imm_arith ? sext_w : (imm_logic ? zext_w : src_b);

   ix_addsub #(.DATA_W(DATA_W)) u_add (
      .op_a  (src_a),
      .op_b  (opnd_b),
      .do_sub(sub_sel),
      .sum   (sum_w),
      .ovf   (ovf_w),
      .less_s(lt_s_w),
      .less_u(lt_u_w)
   );

   ix_logic #(.DATA_W(DATA_W)) u_lgc (
      .op_a(src_a),
      .op_b(opnd_b),
      .fn  (lg_fn),
      .res (logic_w)
   );

   assign sh_amt = sh_var ? src_a[SH_W-1:0] : shamt;

   ix_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
      .din    (src_b),
      .amt    (sh_amt),
      .to_left(sh_left),
      .arith  (sh_arith),
      .dout   (shift_w)
   );

   assign less_bit = less_unsigned ? lt_u_w : lt_s_w;

   always_comb begin
      unique case (rsel)
         RS_SUM:   c_result = sum_w;
         RS_LOGIC: c_result = logic_w;
         RS_LESS:  c_result = {{(DATA_W-1){1'b0}}, less_bit};
         RS_SHIFT: c_result = shift_w;
         RS_UPPER: c_result = upper_w;
         default:  c_result = '0;
      endcase
   end

   assign c_trap  = op_valid & trap_op & ovf_w;
   assign c_valid = op_valid & op_known & ~c_trap;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result       <= '0;
               result_valid <= 1'b0;
               ovf_trap     <= 1'b0;
            end else begin
               result       <= c_result;
               result_valid <= c_valid;
               ovf_trap     <= c_trap;
            end
         end

         // R11: the output stage mirrors last cycle's combinational answer
         assert_reg_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
            result_valid |-> $past(op_valid));
         // R8: a trap at the port came from a signed add, subtract or add-immediate
         assert_trap_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_trap |-> ($past(op_code) == OP_ADD || $past(op_code) == OP_SUB ||
                          $past(op_code) == OP_ADDI));
      end else begin : g_comb
         assign result       = c_result;
         assign result_valid = c_valid;
         assign ovf_trap     = c_trap;
      end
   endgenerate

   // R9: trap and valid never together
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_trap |-> !c_valid);
   // R6: load-upper layout
   assert_upper_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_e == OP_LUI) |-> (c_result[IMM_W-1:0] == '0 &&
                                       c_result[DATA_W-1:DATA_W-IMM_W] == imm));
   // R5: compares yield a single bit
   assert_less_is_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_e == OP_SLT || op_e == OP_SLTU || op_e == OP_SLTI ||
                    op_e == OP_SLTIU)) |-> (c_result[DATA_W-1:1] == '0));
   // R3: bitwise immediates never carry set upper bits into the operand
   assert_logic_imm_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_e == OP_ANDI || op_e == OP_ORI || op_e == OP_XORI)) |->
      (opnd_b[DATA_W-1:IMM_W] == '0));
   // R10: unknown codes produce nothing
   assert_unknown_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code > IX_LAST_OP) |-> (!c_valid && !c_trap && c_result == '0));
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
   localparam int CLK_PERIOD = 10;

   localparam logic [4:0] C_ADD = 0, C_ADDU = 1, C_SUB = 2, C_SUBU = 3,
      C_AND = 4, C_OR = 5, C_XOR = 6, C_NOR = 7, C_SLT = 8, C_SLTU = 9,
      C_ADDI = 10, C_ADDIU = 11, C_SLTI = 12, C_SLTIU = 13, C_ANDI = 14,
      C_ORI = 15, C_XORI = 16, C_LUI = 17, C_SLL = 18, C_SRL = 19, C_SRA = 20,
      C_SLLV = 21, C_SRLV = 22, C_SRAV = 23;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] result;
   logic        result_valid, ovf_trap;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
      .result(result), .result_valid(result_valid), .ovf_trap(ovf_trap)
   );

   function automatic string tag_of(input logic [4:0] op);
      if (op <= 3) return "R1";
      if (op <= 7) return "R2";
      if (op == C_SLT || op == C_SLTU) return "R5";
      if (op <= 13) return "R4";
      if (op <= 16) return "R3";
      if (op == C_LUI) return "R6";
      if (op <= 23) return "R7";
      return "R10";
   endfunction

   // returns {valid, trap, result}
   function automatic logic [33:0] model(input logic [4:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic [4:0] sh, input logic v);
      logic [31:0] se, ze, r;
      logic        t;
      se = {{16{im[15]}}, im};
      ze = {16'h0, im};
      t  = 1'b0;
      r  = '0;
      case (op)
         C_ADD:   begin r = a + b;  t = (a[31] == b[31]) && (r[31] != a[31]); end
         C_ADDU:  r = a + b;
         C_SUB:   begin r = a - b;  t = (a[31] != b[31]) && (r[31] != a[31]); end
         C_SUBU:  r = a - b;
         C_AND:   r = a & b;
         C_OR:    r = a | b;
         C_XOR:   r = a ^ b;
         C_NOR:   r = ~(a | b);
         C_SLT:   r = {31'h0, $signed(a) < $signed(b)};
         C_SLTU:  r = {31'h0, a < b};
         C_ADDI:  begin r = a + se; t = (a[31] == se[31]) && (r[31] != a[31]); end
         C_ADDIU: r = a + se;
         C_SLTI:  r = {31'h0, $signed(a) < $signed(se)};
         C_SLTIU: r = {31'h0, a < se};
         C_ANDI:  r = a & ze;
         C_ORI:   r = a | ze;
         C_XORI:  r = a ^ ze;
         C_LUI:   r = {im, 16'h0};
         C_SLL:   r = b << sh;
         C_SRL:   r = b >> sh;
         C_SRA:   r = $unsigned($signed(b) >>> sh);
         C_SLLV:  r = b << a[4:0];
         C_SRLV:  r = b >> a[4:0];
         C_SRAV:  r = $unsigned($signed(b) >>> a[4:0]);
         default: r = '0;
      endcase
      t = t & v;
      return {v && (op <= 23) && !t, t, r};
   endfunction

   task automatic check(input string tag, input logic [33:0] exp);
      checks++;
      if ({result_valid, ovf_trap, result} !== exp) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got v=%b t=%b r=%h exp v=%b t=%b r=%h",
                  tag, op_code, src_a, src_b, imm, shamt, result_valid, ovf_trap, result,
                  exp[33], exp[32], exp[31:0]);
      end
   endtask

   task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [4:0] sh, input logic v,
                      input string tag);
      @(negedge clk);
      op_code = op; src_a = a; src_b = b; imm = im; shamt = sh; op_valid = v;
      @(negedge clk);
      check(tag, model(op, a, b, im, sh, v));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: outputs cleared in reset
      check("R11", 34'h0);
      rst_n = 1'b1;

      // R4 vs R3: same immediate, different widening
      run(C_ADDI,  32'd100,       32'h0, 16'h8000, 5'd0, 1'b1, "R4");
      run(C_ADDIU, 32'h0000_0001, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R4");
      run(C_SLTIU, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R4");
      run(C_ANDI,  32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, 1'b1, "R3");
      run(C_ORI,   32'h1234_0000, 32'h0, 16'hF00F, 5'd0, 1'b1, "R3");
      run(C_XORI,  32'h0000_0000, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R3");
      // R5: signed vs unsigned ordering of all-ones against one
      run(C_SLT,   32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R5");
      run(C_SLTU,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R5");
      run(C_SLTI,  32'hFFFF_FFFF, 32'h0, 16'h0001, 5'd0, 1'b1, "R5");
      // R6
      run(C_LUI,   32'hDEAD_BEEF, 32'h0, 16'hA5C3, 5'd0, 1'b1, "R6");
      // R7: variable amount uses low five bits only; arithmetic fill
      run(C_SLLV,  32'h0000_0025, 32'h0000_0003, 16'h0, 5'd0, 1'b1, "R7");
      run(C_SRAV,  32'hFFFF_FFE4, 32'h8000_0000, 16'h0, 5'd0, 1'b1, "R7");
      run(C_SRA,   32'h0,         32'hF000_0000, 16'h0, 5'd31, 1'b1, "R7");
      run(C_SRL,   32'h0,         32'hF000_0000, 16'h0, 5'd4, 1'b1, "R7");
      // R8 / R9: signed overflow traps, unsigned twins do not
      run(C_ADD,   32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R9");
      run(C_ADDU,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R8");
      run(C_SUB,   32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b1, "R9");
      run(C_SUBU,  32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b1, "R8");
      run(C_ADDI,  32'h7FFF_FFF0, 32'h0, 16'h0010, 5'd0, 1'b1, "R8");
      run(C_ADDIU, 32'h7FFF_FFF0, 32'h0, 16'h0010, 5'd0, 1'b1, "R8");
      run(C_ADD,   32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 1'b1, "R8");
      run(C_ADD,   32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R10");
      // R10: undefined codes and idle input
      run(5'd25,   32'h1234_5678, 32'h9ABC_DEF0, 16'h1111, 5'd3, 1'b1, "R10");
      run(5'd31,   32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 1'b1, "R10");
      run(C_NOR,   32'h0F0F_0000, 32'h00F0_00FF, 16'h0, 5'd0, 1'b1, "R2");

      // constrained random
      for (int n = 0; n < 600; n++) begin
         logic [4:0]  op;
         logic [31:0] a, b;
         op = 5'($urandom_range(0, 23));
         a  = $urandom();
         b  = $urandom();
         if (($urandom() & 3) == 0) a = {a[31], {31{~a[31]}}};
         run(op, a, b, 16'($urandom()), 5'($urandom()), ($urandom() % 8) != 0, tag_of(op));
      end

      // R11: back into reset clears outputs
      @(negedge clk);
      op_code = C_ADD; src_a = 32'h5; src_b = 32'h6; op_valid = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R11", 34'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule